// File: doc/BRIEF.md
# Pipelined Hyperbolic Rotation Engine with Extended Argument Range

This block evaluates hyperbolic functions of a 16-bit angle in a fully unrolled rotation pipeline. Each rotation uses a shift that is fixed by wiring and an angle constant fixed at elaboration, so there are no barrel shifters and no angle table. Three extra range-widening rotations run ahead of the ordinary shift-by-i rotations. Each of them scales by (1 - 2^-s), with s = 4, 3 and 2, and each is split over two register stages. The first stage forms the scaled cross terms. The second stage does the add or subtract and updates the angle. Together they let the pipeline converge for any 16-bit input, whose range is [-4, +4).

A compile-time parameter chooses how the start vector is seeded and how the outputs are read. In the hyperbolic-pair variant the start vector is (1/gain, 0), and the two outputs are cosh and sinh of the input. In the exponential variant the start vector is (1/gain, 1/gain), and both outputs equal e^z, read with one more integer bit. A valid flag travels with every sample. There is no backpressure: one sample may enter on every clock, and results leave in the order they entered.

Top module: `hyp_cordic_pipe`

## Requirements
- R1: A sample taken in with in_valid high comes out with out_valid high exactly 21 rising edges later, counting the edge that samples it as the first. The 21 stages are 2 for each of 3 range-widening rotations, plus 13 ordinary rotations, plus repeats of shifts 4 and 13.
- R2: The block takes one sample on every clock and never stalls. Back-to-back inputs come out back-to-back, in the order they went in.
- R3: With FUNC = 0, in_z is two's complement with 13 fraction bits. out_x approximates cosh(z) and out_y approximates sinh(z), both two's complement with 10 fraction bits. Each output is within 4 LSB plus 0.04% of the ideal value. The angle left over at the output is at most 64 LSB of the internal 17-fraction-bit angle.
- R4: With FUNC = 1, out_x and out_y are identical on every valid output. Both approximate e^z in two's complement with 9 fraction bits, to the same tolerance as R3.
- R5: The extreme inputs 0x8000 (-4.0) and 0x7FFF (just under +4.0) meet the R3 and R4 tolerances. They do not overflow: the internal value, once its guard bits are dropped, fits in 16 bits.
- R6: A synchronous active-high reset clears every stage's valid flag. out_valid is low after the reset edge, and samples that were in flight when reset arrived never come out.
- R7: When in_valid is low, in_z is ignored. out_valid stays low in the matching output slot, and no extra result appears.
- R8: An input of zero gives out_x = 0x0400 (1.0) and out_y = 0, within 4 LSB, in the hyperbolic-pair variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_z | input | 16 | Angle, two's complement, 13 fraction bits |
| out_valid | output | 1 | Result qualifier, 21 cycles after input |
| out_x | output | 16 | cosh(z) with 10 fraction bits, or e^z with 9 fraction bits |
| out_y | output | 16 | sinh(z) with 10 fraction bits, or e^z with 9 fraction bits |

## Verification
The assertions assume that reset is held for at least one edge before any sample is taken in, and that in_valid is a known level on every edge. They also rely on every 16-bit angle lying inside the convergence range of the widened pipeline. That is what makes both the leftover-angle bound and the no-overflow check hold for any data word. The stimulus drives only 16-bit two's complement words, including both extremes. It releases reset only after several idle edges, and it keeps in_valid at 0 or 1 at all times, including while garbage data sits on in_z during bubbles.

// File: rtl/hyp_cordic_pkg.sv
package hyp_cordic_pkg;

    typedef enum logic {HC_SINH_COSH = 1'b0, HC_EXP = 1'b1} hc_func_e;

    localparam int IO_W         = 16;
    localparam int Z_IO_FRAC    = 13;
    localparam int XY_FRAC_PAIR = 10;
    localparam int XY_FRAC_EXP  = 9;
    localparam int GUARD        = $clog2(IO_W);
    localparam int HEAD_W       = 1;
    localparam int EXT_M        = 2;
    localparam int BASIC_N      = 13;
    localparam int INT_W        = IO_W + HEAD_W + GUARD;
    localparam int Z_FRAC       = Z_IO_FRAC + GUARD;
    localparam int RES_LIMIT    = 64;

    typedef logic signed [INT_W-1:0] hc_word_t;

    typedef struct packed {
        hc_word_t x;
        hc_word_t y;
        hc_word_t z;
    } hc_vec_t;

    typedef struct packed {
        hc_vec_t  v;
        hc_word_t tx;
        hc_word_t ty;
        logic     neg;
    } hc_mid_t;

    // Number of repeated shifts (4, 13, 40, ...) up to n.
    function automatic int repeat_count(input int n);
        int c = 0;
        int k = 4;
        while (k <= n) begin
            c++;
            k = 3 * k + 1;
        end
        return c;
    endfunction

    localparam int REPS         = repeat_count(BASIC_N);
    localparam int PAIRS        = EXT_M + 1;
    localparam int BASIC_STAGES = BASIC_N + REPS;
    localparam int MODS         = PAIRS + BASIC_STAGES;
    localparam int STAGES       = 2 * PAIRS + BASIC_STAGES;

    function automatic int pair_shift(input int p);
        return EXT_M + 2 - p;
    endfunction

    // Shift of the k-th ordinary rotation, with repeats inserted.
    function automatic int basic_shift(input int k);
        int i   = 1;
        int rep = 4;
        bit again = 1'b0;
        for (int j = 0; j < k; j++) begin
            if (i == rep && !again) begin
                again = 1'b1;
            end else begin
                if (i == rep) rep = 3 * rep + 1;
                i++;
                again = 1'b0;
            end
        end
        return i;
    endfunction

    function automatic real atanh_r(input real t);
        return 0.5 * $ln((1.0 + t) / (1.0 - t));
    endfunction

    function automatic hc_word_t angle_fix(input real a);
        return hc_word_t'($rtoi(a * (2.0 ** Z_FRAC) + 0.5));
    endfunction

    function automatic hc_word_t pair_angle(input int p);
        return angle_fix(atanh_r(1.0 - 1.0 / (2.0 ** pair_shift(p))));
    endfunction

    function automatic hc_word_t basic_angle(input int k);
        return angle_fix(atanh_r(1.0 / (2.0 ** basic_shift(k))));
    endfunction

    function automatic real pipe_gain();
        real g = 1.0;
        real t;
        for (int p = 0; p < PAIRS; p++) begin
            t = 1.0 - 1.0 / (2.0 ** pair_shift(p));
            g = g * $sqrt(1.0 - t * t);
        end
        for (int k = 0; k < BASIC_STAGES; k++) begin
            t = 1.0 / (2.0 ** basic_shift(k));
            g = g * $sqrt(1.0 - t * t);
        end
        return g;
    endfunction

    function automatic int xy_frac(input hc_func_e f);
        return ((f == HC_EXP) ? XY_FRAC_EXP : XY_FRAC_PAIR) + GUARD;
    endfunction

    function automatic hc_word_t seed_fix(input hc_func_e f);
        return hc_word_t'($rtoi((2.0 ** xy_frac(f)) / pipe_gain() + 0.5));
    endfunction

    function automatic int mag(input hc_word_t v);
        return (v < 0) ? -int'(v) : int'(v);
    endfunction

endpackage

// File: rtl/hyp_cordic_seed.sv
module hyp_cordic_seed
    import hyp_cordic_pkg::*;
#(
    parameter hc_func_e FUNC = HC_SINH_COSH
) (
    input  logic [IO_W-1:0] z_in,
    output hc_vec_t         seed
);

    localparam hc_word_t X_INIT = seed_fix(FUNC);

    assign seed.x = X_INIT;
    assign seed.z = {{HEAD_W{z_in[IO_W-1]}}, z_in, {GUARD{1'b0}}};

    generate
        if (FUNC == HC_EXP) begin : g_exp_seed
            assign seed.y = X_INIT;
        end else begin : g_pair_seed
            assign seed.y = '0;
        end
    endgenerate

endmodule

// File: rtl/hyp_cordic_expand_pair.sv
module hyp_cordic_expand_pair
    import hyp_cordic_pkg::*;
#(
    parameter int       SHIFT = 2,
    parameter hc_word_t ANGLE = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    vld_i,
    input  hc_vec_t d_i,
    output logic    vld_o,
    output hc_vec_t d_o
);

    localparam int ANG_MAG = int'(ANGLE);

    hc_mid_t mid_n;
    hc_mid_t mid_q;
    logic    vld_mid;
    hc_vec_t nxt;

    // First half: scaled cross terms (1 - 2^-SHIFT) * x and * y.
    always_comb begin
        mid_n.v   = d_i;
        mid_n.tx  = d_i.x - hc_word_t'($signed(d_i.x) >>> SHIFT);
        mid_n.ty  = d_i.y - hc_word_t'($signed(d_i.y) >>> SHIFT);
        mid_n.neg = d_i.z[INT_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) vld_mid <= 1'b0;
        else     vld_mid <= vld_i;
    end

    always_ff @(posedge clk) begin
        mid_q <= mid_n;
    end

    // Second half: add/subtract and angle update.
    always_comb begin
        nxt.x = mid_q.neg ? mid_q.v.x - mid_q.ty : mid_q.v.x + mid_q.ty;
        nxt.y = mid_q.neg ? mid_q.v.y - mid_q.tx : mid_q.v.y + mid_q.tx;
        nxt.z = mid_q.neg ? mid_q.v.z + ANGLE    : mid_q.v.z - ANGLE;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_mid;
    end

    always_ff @(posedge clk) begin
        d_o <= nxt;
    end

    AST_PAIR_Z_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (mag(d_o.z) <= mag($past(mid_q.v.z)) || mag(d_o.z) <= ANG_MAG)); // R3

endmodule

// File: rtl/hyp_cordic_rot_stage.sv
module hyp_cordic_rot_stage
    import hyp_cordic_pkg::*;
#(
    parameter int       SHIFT = 1,
    parameter hc_word_t ANGLE = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    vld_i,
    input  hc_vec_t d_i,
    output logic    vld_o,
    output hc_vec_t d_o
);

    localparam int ANG_MAG = int'(ANGLE);

    logic     neg;
    hc_word_t xs;
    hc_word_t ys;
    hc_vec_t  nxt;

    always_comb begin
        neg   = d_i.z[INT_W-1];
        xs    = hc_word_t'($signed(d_i.x) >>> SHIFT);
        ys    = hc_word_t'($signed(d_i.y) >>> SHIFT);
        nxt.x = neg ? d_i.x - ys : d_i.x + ys;
        nxt.y = neg ? d_i.y - xs : d_i.y + xs;
        nxt.z = neg ? d_i.z + ANGLE : d_i.z - ANGLE;
    end

    always_ff @(posedge clk) begin
        if (rst) vld_o <= 1'b0;
        else     vld_o <= vld_i;
    end

    always_ff @(posedge clk) begin
        d_o <= nxt;
    end

    AST_ROT_Z_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> (mag(d_o.z) <= mag($past(d_i.z)) || mag(d_o.z) <= ANG_MAG)); // R3

endmodule

// File: rtl/hyp_cordic_pipe.sv
module hyp_cordic_pipe
    import hyp_cordic_pkg::*;
#(
    parameter hc_func_e FUNC = HC_SINH_COSH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IO_W-1:0] in_z,
    output logic            out_valid,
    output logic [IO_W-1:0] out_x,
    output logic [IO_W-1:0] out_y
);

    logic    vld_c [MODS+1];
    hc_vec_t vec_c [MODS+1];
    hc_vec_t fin;
    hc_word_t x_sh;
    hc_word_t y_sh;

    assign vld_c[0] = in_valid;

    hyp_cordic_seed #(.FUNC(FUNC)) u_seed (
        .z_in (in_z),
        .seed (vec_c[0])
    );

    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            hyp_cordic_expand_pair #(
                .SHIFT (pair_shift(p)),
                .ANGLE (pair_angle(p))
            ) u_pair (
                .clk   (clk),
                .rst   (rst),
                .vld_i (vld_c[p]),
                .d_i   (vec_c[p]),
                .vld_o (vld_c[p+1]),
                .d_o   (vec_c[p+1])
            );
        end
        for (genvar k = 0; k < BASIC_STAGES; k++) begin : g_rot
            hyp_cordic_rot_stage #(
                .SHIFT (basic_shift(k)),
                .ANGLE (basic_angle(k))
            ) u_rot (
                .clk   (clk),
                .rst   (rst),
                .vld_i (vld_c[PAIRS+k]),
                .d_i   (vec_c[PAIRS+k]),
                .vld_o (vld_c[PAIRS+k+1]),
                .d_o   (vec_c[PAIRS+k+1])
            );
        end
    endgenerate

    assign fin       = vec_c[MODS];
    assign out_valid = vld_c[MODS];
    assign x_sh      = hc_word_t'($signed(fin.x) >>> GUARD);
    assign y_sh      = hc_word_t'($signed(fin.y) >>> GUARD);
    assign out_x     = x_sh[IO_W-1:0];
    assign out_y     = y_sh[IO_W-1:0];

    // Accepted-minus-delivered count, used only by the checks below.
    int inflight;
    always_ff @(posedge clk) begin
        if (rst) inflight <= 0;
        else     inflight <= inflight + int'(in_valid) - int'(out_valid);
    end

    AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (rst)
        inflight <= STAGES); // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> inflight != 0); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((x_sh[INT_W-1:IO_W-1] == '0 || &x_sh[INT_W-1:IO_W-1]) &&
                       (y_sh[INT_W-1:IO_W-1] == '0 || &y_sh[INT_W-1:IO_W-1]))); // R5

    AST_ANGLE_RESIDUAL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> mag(fin.z) <= RES_LIMIT); // R3

    generate
        if (FUNC == HC_EXP) begin : g_exp_chk
            AST_EXP_TWIN: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> out_x == out_y); // R4
        end
    endgenerate

endmodule

// File: tb/tb_hyp_cordic_pipe.sv
module tb_hyp_cordic_pipe;
    import hyp_cordic_pkg::*;

    localparam int LAT = 21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_z = '0;
    logic        out_valid, e_valid;
    logic [15:0] out_x, out_y, e_x, e_y;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    bit  started = 1'b0;
    bit  finished = 1'b0;

    typedef struct {
        int    due;
        real   zr;
        string tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    bit    due_now;

    hyp_cordic_pipe #(.FUNC(HC_SINH_COSH)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(in_z),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
    );

    hyp_cordic_pipe #(.FUNC(HC_EXP)) dut_exp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(in_z),
        .out_valid(e_valid), .out_x(e_x), .out_y(e_y)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_bit(input string req, input string what, input logic act, input logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", req, what, act, expv, cyc);
        end
    endtask

    task automatic check_near(input string req, input string what, input logic [15:0] act, input real e_lsb);
        real a;
        real d;
        real tol;
        a = $itor($signed(act));
        d = a - e_lsb;
        if (d < 0.0) d = -d;
        tol = 4.0 + ((e_lsb < 0.0) ? -e_lsb : e_lsb) * 4.0e-4;
        total++;
        if (d > tol) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0.2f", req, what, $signed(act), e_lsb);
        end
    endtask

    // Monitor: pops the scoreboard when a result is due.
    always @(negedge clk) begin
        #1;
        if (started && !rst && !finished) begin
            due_now = (exp_q.size() > 0) && (exp_q[0].due == cyc);
            check_bit(due_now ? "R1" : "R7", "out_valid", out_valid, due_now);
            check_bit("R2", "exp variant valid", e_valid, due_now);
            if (due_now) begin
                cur = exp_q.pop_front();
                check_near(cur.tag, "cosh", out_x, 1024.0 * ($exp(cur.zr) + $exp(-cur.zr)) / 2.0);
                check_near(cur.tag, "sinh", out_y, 1024.0 * ($exp(cur.zr) - $exp(-cur.zr)) / 2.0);
                check_near("R4", "exp x", e_x, 512.0 * $exp(cur.zr));
                check_near("R4", "exp y", e_y, 512.0 * $exp(cur.zr));
                check_bit("R4", "exp x==y", (e_x == e_y), 1'b1);
            end
        end
    end

    task automatic push_z(input logic [15:0] z, input string tag);
        item_t it;
        in_valid = 1'b1;
        in_z     = z;
        it.due   = cyc + LAT;
        it.zr    = $itor($signed(z)) / 8192.0;
        it.tag   = tag;
        exp_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_z     = 16'h5A3C ^ 16'(i * 977);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state
        check_bit("R6", "out_valid in reset", out_valid, 1'b0);
        check_bit("R6", "exp out_valid in reset", e_valid, 1'b0);
        rst = 1'b0;
        started = 1'b1;
        gap(3);

        // R8: zero angle
        push_z(16'h0000, "R8");
        gap(2);

        // R3: directed angles
        push_z(16'h2000, "R3");   // 1.0
        push_z(16'hE000, "R3");   // -1.0
        push_z(16'h4000, "R3");   // 2.0
        push_z(16'h1000, "R3");   // 0.5
        push_z(16'h9666, "R3");   // about -3.3
        gap(1);

        // R5: range extremes
        push_z(16'h7FFF, "R5");
        push_z(16'h8000, "R5");
        gap(4);

        // R2: back-to-back sweep across the whole range
        for (int k = 0; k < 48; k++)
            push_z(16'(-32768 + k * 1365), "R2");

        // R7: bubbles with garbage data while in_valid is low
        for (int k = 0; k < 12; k++) begin
            push_z(16'(k * 4099 - 20000), "R7");
            gap(1 + (k % 2));
        end

        while (exp_q.size() != 0) @(negedge clk);
        gap(4);

        // R6: reset with samples in flight
        for (int k = 0; k < 5; k++) push_z(16'(k * 3000), "R6");
        gap(3);
        rst = 1'b1;
        exp_q.delete();
        @(negedge clk);
        check_bit("R6", "out_valid after reset edge", out_valid, 1'b0);
        check_bit("R6", "exp out_valid after reset edge", e_valid, 1'b0);
        rst = 1'b0;
        gap(30);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            finish_run();
        end
    end

endmodule